// File: doc/BRIEF.md
# Parallel Port Attach/Release Sequencer

This block is the host side of a parallel port. It drives the eight data lines and an eight-bit control port value, where bit 7 lights an activity indicator. It plays a fixed handshake that wakes, attaches or releases an adapter chip sitting behind the port. A one-cycle start pulse, together with a two-bit mode code, launches a run. During the handshake a series of distinctive data bytes goes out. At three points the block captures the status lines, each under its own mask, so that the host can tell whether the adapter answered as expected.

Every output step is held for a parameterised number of clocks, HOLD (default 4), before the next step or capture. When a run ends, a one-cycle done pulse is raised. For attach and release runs, a match flag reports whether all three captures agreed with the expected answer. The full-attach mode chains a wake run and an attach run, then adds a short control prologue and four writes into the adapter's internal registers.

Top module: `ppsq_top`

## Requirements
- R1: After reset, data_o is 0xFF and ctrl_o is 0x0C. busy_o, done_o and match_o are 0, and all three captures are 0x00.
- R2: mode_i selects the run. 0 is wake: one handshake with key byte 0x00. 1 is attach: one handshake with key byte 0xE0. 2 is release: one handshake with key byte 0x30, followed by ctrl 0x8C. 3 is full attach: a wake handshake, then an attach handshake, then the tail given in R6.
- R3: One handshake is 16 steps, in this order. ctrl 0x04. Data 0x22, 0xAA, 0x55, 0x00, 0xFF. Capture A. Data 0x87. Capture B. Data 0x78. Capture C. Data set to the key byte. ctrl 0x04, 0x05, 0x04. Data 0xFF. A capture step changes no output.
- R4: Capture A and capture B store status_i AND 0xB8. Capture C stores status_i AND 0x38. Each is taken on the last cycle of its step. Captures keep their values until they are overwritten.
- R5: With the start pulse accepted on clock edge E0, the output change of step i appears after edge E(1+i*HOLD) and is held for HOLD cycles.
- R6: The full-attach tail comes after the second handshake. It is data 0x00, ctrl 0x01, ctrl 0x04, then four register writes with (address, value) pairs (0x08,0x10), (0x0C,0x14), (0x0A,0x38) and (0x12,0x10). Each write is four steps: data 0x60+address, ctrl 0x01, data value, ctrl 0x04.
- R7: A release run ends with ctrl_o at 0x8C.
- R8: busy_o is high from the edge after start until the end of the last step. done_o is high for exactly one cycle, after edge E((L+1)*HOLD), where L is the index of the last step. busy_o falls on that same edge.
- R9: At done, match_o is set under two conditions. For modes 1 and 3, the captures must be (0xB8, 0x18, 0x30). For mode 2, they must be (0xB8, 0x18, 0x38). In mode 0, match_o is never set. match_o clears when a new run starts.
- R10: A start pulse while busy_o is high is ignored. The running sequence and its mode continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken when idle |
| mode_i | input | 2 | Run mode (R2) |
| status_i | input | 8 | Port status lines |
| data_o | output | 8 | Port data lines |
| ctrl_o | output | 8 | Control port value, bit 7 = activity indicator |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| match_o | output | 1 | Captures equal the expected answer |
| cap_a_o | output | 8 | Capture A |
| cap_b_o | output | 8 | Capture B |
| cap_c_o | output | 8 | Capture C |

## Verification
The bench models the adapter by making status_i depend on the data byte currently driven. Each capture therefore sees a different word, so a swapped mask, or a capture taken one step early, shows up as a wrong capture value. Every step's output is compared on the exact cycle R5 predicts. A design that miscounts the hold, drops a step or reorders a step fails that comparison. Directed runs cover the following cases:
- captures that fit release but not attach, so match_o must stay low;
- a wake run whose captures would otherwise match;
- a second start pulse in the middle of a run, which a faulty design would restart on or switch mode for.

// File: rtl/ppsq_pkg.sv
package ppsq_pkg;
  localparam int unsigned STEPS_FULL = 51;
  localparam int unsigned IDX_W      = $clog2(STEPS_FULL);

  localparam logic [1:0] MODE_WAKE = 2'd0;
  localparam logic [1:0] MODE_ATT  = 2'd1;
  localparam logic [1:0] MODE_REL  = 2'd2;
  localparam logic [1:0] MODE_FULL = 2'd3;

  localparam logic [7:0] MASK_AB = 8'hB8;
  localparam logic [7:0] MASK_C  = 8'h38;

  typedef enum logic [2:0] {
    K_DATA, K_CTRL, K_CAP_A, K_CAP_B, K_CAP_C
  } step_kind_e;

  typedef struct packed {
    step_kind_e kind;
    logic [7:0] val;
    logic       last;
  } step_t;
endpackage

// File: rtl/ppsq_step_rom.sv
module ppsq_step_rom
  import ppsq_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o
);
  function automatic step_t mk(step_kind_e k, logic [7:0] v);
    step_t s;
    s.kind = k;
    s.val  = v;
    s.last = 1'b0;
    return s;
  endfunction

  // one handshake, 16 steps; key is the mode byte
  function automatic step_t hs(logic [3:0] k, logic [7:0] key);
    case (k)
      4'd0:    return mk(K_CTRL, 8'h04);
      4'd1:    return mk(K_DATA, 8'h22);
      4'd2:    return mk(K_DATA, 8'hAA);
      4'd3:    return mk(K_DATA, 8'h55);
      4'd4:    return mk(K_DATA, 8'h00);
      4'd5:    return mk(K_DATA, 8'hFF);
      4'd6:    return mk(K_CAP_A, 8'h00);
      4'd7:    return mk(K_DATA, 8'h87);
      4'd8:    return mk(K_CAP_B, 8'h00);
      4'd9:    return mk(K_DATA, 8'h78);
      4'd10:   return mk(K_CAP_C, 8'h00);
      4'd11:   return mk(K_DATA, key);
      4'd12:   return mk(K_CTRL, 8'h04);
      4'd13:   return mk(K_CTRL, 8'h05);
      4'd14:   return mk(K_CTRL, 8'h04);
      default: return mk(K_DATA, 8'hFF);
    endcase
  endfunction

  function automatic logic [7:0] wr_addr(logic [1:0] w);
    case (w)
      2'd0:    return 8'h08;
      2'd1:    return 8'h0C;
      2'd2:    return 8'h0A;
      default: return 8'h12;
    endcase
  endfunction

  function automatic logic [7:0] wr_val(logic [1:0] w);
    case (w)
      2'd0:    return 8'h10;
      2'd1:    return 8'h14;
      2'd2:    return 8'h38;
      default: return 8'h10;
    endcase
  endfunction

  logic [IDX_W-1:0] off;

  always_comb begin
    off    = idx_i - IDX_W'(35);
    step_o = mk(K_DATA, 8'hFF);
    case (mode_i)
      MODE_FULL: begin
        if (idx_i < IDX_W'(16))      step_o = hs(idx_i[3:0], 8'h00);
        else if (idx_i < IDX_W'(32)) step_o = hs(idx_i[3:0], 8'hE0);
        else if (idx_i == IDX_W'(32)) step_o = mk(K_DATA, 8'h00);
        else if (idx_i == IDX_W'(33)) step_o = mk(K_CTRL, 8'h01);
        else if (idx_i == IDX_W'(34)) step_o = mk(K_CTRL, 8'h04);
        else begin
          case (off[1:0])
            2'd0:    step_o = mk(K_DATA, 8'h60 + wr_addr(off[3:2]));
            2'd1:    step_o = mk(K_CTRL, 8'h01);
            2'd2:    step_o = mk(K_DATA, wr_val(off[3:2]));
            default: step_o = mk(K_CTRL, 8'h04);
          endcase
        end
        step_o.last = (idx_i == IDX_W'(STEPS_FULL - 1));
      end
      MODE_REL: begin
        if (idx_i < IDX_W'(16)) step_o = hs(idx_i[3:0], 8'h30);
        else                    step_o = mk(K_CTRL, 8'h8C);
        step_o.last = (idx_i == IDX_W'(16));
      end
      default: begin
        step_o = hs(idx_i[3:0], (mode_i == MODE_ATT) ? 8'hE0 : 8'h00);
        step_o.last = (idx_i == IDX_W'(15));
      end
    endcase
  end
endmodule

// File: rtl/ppsq_hold_timer.sv
module ppsq_hold_timer #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic entry_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt_q;

  assign entry_o  = (cnt_q == '0);
  assign expire_o = (cnt_q == CNT_W'(HOLD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end

  AST_HOLD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(HOLD)); // R5
endmodule

// File: rtl/ppsq_capture.sv
module ppsq_capture
  import ppsq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cap_en_i,
  input  logic [7:0] status_i,
  input  logic [1:0] mode_i,
  output logic [7:0] cap_a_o,
  output logic [7:0] cap_b_o,
  output logic [7:0] cap_c_o,
  output logic       ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_a_o <= '0;
      cap_b_o <= '0;
      cap_c_o <= '0;
    end else begin
      if (cap_en_i[0]) cap_a_o <= status_i & MASK_AB;
      if (cap_en_i[1]) cap_b_o <= status_i & MASK_AB;
      if (cap_en_i[2]) cap_c_o <= status_i & MASK_C;
    end
  end

  logic ab_ok;
  assign ab_ok = (cap_a_o == 8'hB8) && (cap_b_o == 8'h18);

  always_comb begin
    case (mode_i)
      MODE_ATT, MODE_FULL: ok_o = ab_ok && (cap_c_o == 8'h30);
      MODE_REL:            ok_o = ab_ok && (cap_c_o == 8'h38);
      default:             ok_o = 1'b0;
    endcase
  end

  AST_CAP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cap_en_i)); // R4
  AST_CAP_C_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_c_o & ~MASK_C) == 8'h00); // R4
endmodule

// File: rtl/ppsq_top.sv
module ppsq_top
  import ppsq_pkg::*;
#(
  parameter int unsigned HOLD = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic [7:0] status_i,
  output logic [7:0] data_o,
  output logic [7:0] ctrl_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       match_o,
  output logic [7:0] cap_a_o,
  output logic [7:0] cap_b_o,
  output logic [7:0] cap_c_o
);
  logic             busy_q;
  logic [1:0]       mode_q;
  logic [IDX_W-1:0] idx_q;
  logic             entry, expire, accept, ok;
  logic [2:0]       cap_en;
  step_t            step;

  assign accept = start_i && !busy_q;
  assign busy_o = busy_q;

  ppsq_step_rom u_rom (
    .mode_i (mode_q),
    .idx_i  (idx_q),
    .step_o (step)
  );

  ppsq_hold_timer #(.HOLD(HOLD)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .run_i    (busy_q),
    .entry_o  (entry),
    .expire_o (expire)
  );

  assign cap_en[0] = busy_q && expire && (step.kind == K_CAP_A);
  assign cap_en[1] = busy_q && expire && (step.kind == K_CAP_B);
  assign cap_en[2] = busy_q && expire && (step.kind == K_CAP_C);

  ppsq_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (cap_en),
    .status_i (status_i),
    .mode_i   (mode_q),
    .cap_a_o  (cap_a_o),
    .cap_b_o  (cap_b_o),
    .cap_c_o  (cap_c_o),
    .ok_o     (ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      mode_q  <= MODE_WAKE;
      idx_q   <= '0;
      data_o  <= 8'hFF;
      ctrl_o  <= 8'h0C;
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          mode_q  <= mode_i;
          idx_q   <= '0;
          match_o <= 1'b0;
        end
      end else begin
        if (entry) begin
          if (step.kind == K_DATA) data_o <= step.val;
          if (step.kind == K_CTRL) ctrl_o <= step.val;
        end
        if (expire) begin
          if (step.last) begin
            busy_q  <= 1'b0;
            done_o  <= 1'b1;
            match_o <= ok;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_q))); // R8
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(mode_q)); // R10
  AST_WAKE_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (mode_q != MODE_WAKE)); // R9
  AST_DATA_AT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> $past(busy_q && entry)); // R5
  AST_CTRL_AT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(busy_q && entry)); // R5
endmodule

// File: tb/sim_ppsq_top.sv
`timescale 1ns/1ps
module sim_ppsq_top;
  localparam int unsigned HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] status;
  logic [7:0] data, ctrl, cap_a, cap_b, cap_c;
  logic       busy, done, match;
  logic [7:0] sa = 8'h00, sb = 8'h00, sc = 8'h00;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int         ek [64];
  logic [7:0] ev [64];
  int         n;
  logic [7:0] ed, ec;

  always #4 clk = ~clk;

  // adapter model: status reacts to the byte on the data lines
  assign status = (data == 8'hFF) ? sa : (data == 8'h87) ? sb :
                  (data == 8'h78) ? sc : 8'h00;

  ppsq_top #(.HOLD(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .status_i(status), .data_o(data), .ctrl_o(ctrl), .busy_o(busy),
    .done_o(done), .match_o(match), .cap_a_o(cap_a), .cap_b_o(cap_b),
    .cap_c_o(cap_c)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add(int k, logic [7:0] v);
    ek[n] = k; ev[n] = v; n++;
  endtask

  // kinds: 0 data, 1 ctrl, 2 capture
  task automatic add_hs(logic [7:0] key);
    add(1, 8'h04); add(0, 8'h22); add(0, 8'hAA); add(0, 8'h55);
    add(0, 8'h00); add(0, 8'hFF); add(2, 0); add(0, 8'h87); add(2, 0);
    add(0, 8'h78); add(2, 0); add(0, key); add(1, 8'h04); add(1, 8'h05);
    add(1, 8'h04); add(0, 8'hFF);
  endtask

  task automatic add_wr(logic [7:0] a, logic [7:0] v);
    add(0, 8'h60 + a); add(1, 8'h01); add(0, v); add(1, 8'h04);
  endtask

  task automatic build(logic [1:0] m);
    n = 0;
    case (m)
      2'd0: add_hs(8'h00);
      2'd1: add_hs(8'hE0);
      2'd2: begin add_hs(8'h30); add(1, 8'h8C); end        // R7
      default: begin
        add_hs(8'h00); add_hs(8'hE0);                       // R6
        add(0, 8'h00); add(1, 8'h01); add(1, 8'h04);
        add_wr(8'h08, 8'h10); add_wr(8'h0C, 8'h14);
        add_wr(8'h0A, 8'h38); add_wr(8'h12, 8'h10);
      end
    endcase
  endtask

  function automatic logic exp_match(logic [1:0] m);
    logic ab;
    ab = ((sa & 8'hB8) == 8'hB8) && ((sb & 8'hB8) == 8'h18);
    if (m == 2'd1 || m == 2'd3) return ab && ((sc & 8'h38) == 8'h30);
    if (m == 2'd2)              return ab && ((sc & 8'h38) == 8'h38);
    return 1'b0;
  endfunction

  task automatic run(logic [1:0] m, bit inject);
    build(m);
    @(negedge clk); start = 1'b1; mode = m;
    @(posedge clk); #1; start = 1'b0;
    chk("R8 busy after start", busy, 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (ek[i] == 0) ed = ev[i];
      if (ek[i] == 1) ec = ev[i];
      chk($sformatf("R3/R5 data m%0d step%0d", m, i), data, ed);
      chk($sformatf("R3/R5 ctrl m%0d step%0d", m, i), ctrl, ec);
      if (i == 3 && inject) begin start = 1'b1; mode = ~m; end
      if (i == 4) start = 1'b0;
      if (i == n - 1) chk("R8 no early done", done, 0);
      for (int h = 1; h < HOLD; h++) @(posedge clk);
    end
    #1;
    chk("R8 done pulse", done, 1);
    chk("R8 busy falls", busy, 0);
    chk("R4 capture A", cap_a, sa & 8'hB8);
    chk("R4 capture B", cap_b, sb & 8'hB8);
    chk("R4 capture C", cap_c, sc & 8'h38);
    chk($sformatf("R9 match m%0d", m), match, exp_match(m));
    if (m == 2'd2) chk("R7 release ctrl", ctrl, 8'h8C);
    @(posedge clk); #1;
    chk("R8 done one cycle", done, 0);
    if (inject) chk("R10 no restart", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    ed = 8'hFF; ec = 8'h0C;
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data", data, 8'hFF);
    chk("R1 ctrl", ctrl, 8'h0C);
    chk("R1 flags", {busy, done, match}, 3'b000);
    chk("R1 caps", {cap_a, cap_b, cap_c}, 24'h0);

    sa = 8'hFF; sb = 8'h1C; sc = 8'hB4;            // attach answer
    run(2'd1, 0);                                   // R2
    run(2'd2, 0);                                   // R2, answer fits attach only
    sc = 8'h3C;
    run(2'd2, 0);                                   // release answer
    run(2'd1, 0);
    run(2'd0, 0);                                   // R9 wake never matches
    sc = 8'h30;
    run(2'd3, 0);                                   // R6 full attach
    run(2'd1, 1);                                   // R10 start while busy
    for (int k = 0; k < 12; k++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) begin
        sa = 8'hB8 | 8'($urandom_range(0, 255) & 8'h47);
        sb = 8'h18 | 8'($urandom_range(0, 255) & 8'h47);
        sc = ($urandom_range(0, 1) ? 8'h38 : 8'h30) | 8'($urandom_range(0, 255) & 8'hC7);
      end else begin
        sa = 8'($urandom); sb = 8'($urandom); sc = 8'($urandom);
      end
      run(m, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule